// File: doc/BRIEF.md
# Battery-Backed Tamper Event Latch

This block records a tamper event from an active-high sensing input into a sticky flag. The flag sits in an always-on domain that runs from the backup battery, so an event is caught and kept while the rest of the system is unpowered. The interrupt request the flag produces is held off while main power is absent. It appears as soon as the main-power-good indication returns.

Software sees the flag through a status read port. It removes the flag with a level-type clear control bit in a configuration register. While that bit reads 1 the flag is held at 0. Software must write the bit back to 0 before a new event can be recorded. A mask input blocks the flag from reaching the interrupt line, but the status read still shows the flag. The tamper input is asynchronous, so it passes through a synchronizer chain before its rising edge is detected. Only loss of the battery domain resets the flag and the clear bit.

Top module: `tamper_latch_top`

## Requirements
- R1: While `bat_rst` is high at a clock edge, the flag, the clear bit and `irq_o` go to 0. No other input resets them.
- R2: When `tamper_i` goes from 0 to 1, `stat_flag_o` reads 1 after the third rising clock edge that follows: two synchronizer stages, then capture. The flag stays 1 after `tamper_i` returns to 0.
- R3: `stat_flag_o` shows the flag at all times. It does not depend on `mask_i` or `pwr_ok_i`.
- R4: A clock edge with `cfg_wr_en_i` = 1 and `pwr_ok_i` = 1 loads `cfg_wr_clr_i` into the clear bit, read back on `cfg_clr_o`. The bit then keeps its value until a later write changes it.
- R5: While the clear bit is 1, the flag is 0 from the next clock edge on. It is not set again until `tamper_i` rises anew after the clear bit has returned to 0. A level held high through the clear period does not count as a new rise.
- R6: `irq_o` is 1 exactly when the flag is 1, `mask_i` is 0 and `pwr_ok_i` is 1. `mask_i` = 1 blocks the flag from the interrupt.
- R7: A tamper rise while `pwr_ok_i` = 0 still sets the flag. `irq_o` stays 0 while power is off and becomes 1 in the same cycle that `pwr_ok_i` returns to 1.
- R8: A write while `pwr_ok_i` = 0 is ignored. The clear bit and the flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| bat_rst | input | 1 | Synchronous active-high reset on battery-domain loss |
| tamper_i | input | 1 | Asynchronous active-high tamper sense input |
| pwr_ok_i | input | 1 | Main power good, synchronous to `clk` |
| cfg_wr_en_i | input | 1 | Write strobe for the clear control bit |
| cfg_wr_clr_i | input | 1 | Value written into the clear control bit |
| mask_i | input | 1 | 1 blocks the flag from the interrupt output |
| stat_flag_o | output | 1 | Status read of the sticky tamper flag |
| cfg_clr_o | output | 1 | Readback of the clear control bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The first pattern is a single rise-and-fall pulse with power on. It shows the capture latency and that the flag stays set after the input falls. The second holds the input high through a full clear cycle, which separates true edge capture from level capture: a level-sensitive design would set the flag again. The third raises the input while power is off and then restores power, which confirms that the event is recorded and the interrupt is deferred. The mask and powered-off write patterns show that each gate acts only on the path it guards: the status read, the interrupt, or the clear bit.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int unsigned TL_SYNC_STAGES = 2;

    // Register state of the always-on domain
    typedef struct packed {
        logic flag;
        logic clr;
    } tl_state_t;

    // Interrupt gating: flag is visible only when unmasked and powered
    function automatic logic tl_irq_gate(input tl_state_t st,
                                         input logic      mask,
                                         input logic      pwr_ok);
        return st.flag & ~mask & pwr_ok;
    endfunction

endpackage

// File: rtl/tl_sync.sv
module tl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/tl_clear_reg.sv
module tl_clear_reg (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok_i,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    output logic clr_o
);
    logic clr_q;

    always_ff @(posedge clk) begin
        if (rst)                      clr_q <= 1'b0;
        else if (wr_en_i && pwr_ok_i) clr_q <= wr_bit_i;
    end

    assign clr_o = clr_q;

    // R8
    unpowered_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !pwr_ok_i) |=> $stable(clr_q));

    // R4
    clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(clr_q));
endmodule

// File: rtl/tl_event_latch.sv
module tl_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic clr_i,
    output logic flag_o
);
    logic prev_q;
    logic flag_q;
    logic rise;

    assign rise = lvl_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (clr_i)     flag_q <= 1'b0;
            else if (rise) flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    // R5
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !flag_q);

    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

    // R5
    set_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && (!lvl_i || prev_q)) |=> !flag_q);
endmodule

// File: rtl/tamper_latch_top.sv
module tamper_latch_top
    import tl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = TL_SYNC_STAGES
) (
    input  logic clk,
    input  logic bat_rst,
    input  logic tamper_i,
    input  logic pwr_ok_i,
    input  logic cfg_wr_en_i,
    input  logic cfg_wr_clr_i,
    input  logic mask_i,
    output logic stat_flag_o,
    output logic cfg_clr_o,
    output logic irq_o
);
    logic      tamper_sync;
    tl_state_t st;

    tl_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (bat_rst),
        .d_i (tamper_i),
        .q_o (tamper_sync)
    );

    tl_clear_reg clear_i (
        .clk      (clk),
        .rst      (bat_rst),
        .pwr_ok_i (pwr_ok_i),
        .wr_en_i  (cfg_wr_en_i),
        .wr_bit_i (cfg_wr_clr_i),
        .clr_o    (st.clr)
    );

    tl_event_latch latch_i (
        .clk    (clk),
        .rst    (bat_rst),
        .lvl_i  (tamper_sync),
        .clr_i  (st.clr),
        .flag_o (st.flag)
    );

    assign stat_flag_o = st.flag;
    assign cfg_clr_o   = st.clr;
    assign irq_o       = tl_irq_gate(st, mask_i, pwr_ok_i);

    // R7
    irq_needs_power_chk: assert property (@(posedge clk) disable iff (bat_rst)
        irq_o |-> pwr_ok_i);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (bat_rst)
        irq_o |-> (stat_flag_o && !mask_i));
endmodule

// File: tb/tamper_latch_top_tb_top.sv
module tamper_latch_top_tb_top;
    logic clk = 1'b0;
    logic bat_rst, tamper, pwr_ok, wr_en, wr_clr, mask;
    logic stat, clr_rd, irq;
    int   checks = 0;
    int   errors = 0;

    always #2 clk = ~clk;

    tamper_latch_top dut_i (
        .clk          (clk),
        .bat_rst      (bat_rst),
        .tamper_i     (tamper),
        .pwr_ok_i     (pwr_ok),
        .cfg_wr_en_i  (wr_en),
        .cfg_wr_clr_i (wr_clr),
        .mask_i       (mask),
        .stat_flag_o  (stat),
        .cfg_clr_o    (clr_rd),
        .irq_o        (irq)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_clear(input logic b);
        wr_en  = 1'b1;
        wr_clr = b;
        tick(1);
        wr_en  = 1'b0;
    endtask

    task automatic t_reset;
        bat_rst = 1'b1; tamper = 1'b0; pwr_ok = 1'b1;
        wr_en = 1'b0; wr_clr = 1'b0; mask = 1'b0;
        tick(2);
        bat_rst = 1'b0;
        tick(1);
        chk("R1 flag after reset", stat, 1'b0);
        chk("R1 clear bit after reset", clr_rd, 1'b0);
        chk("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_pulse_capture;
        tamper = 1'b1;
        tick(2);
        chk("R2 flag not yet after two edges", stat, 1'b0);
        tick(1);
        chk("R2 flag set after third edge", stat, 1'b1);
        chk("R6 irq with flag unmasked powered", irq, 1'b1);
        tamper = 1'b0;
        tick(5);
        chk("R2 flag sticky after input low", stat, 1'b1);
    endtask

    task automatic t_clear_cycle;
        write_clear(1'b1);
        chk("R4 clear bit reads 1", clr_rd, 1'b1);
        tick(1);
        chk("R5 flag cleared by clear bit", stat, 1'b0);
        tick(3);
        chk("R4 clear bit held", clr_rd, 1'b1);
        write_clear(1'b0);
        chk("R4 clear bit reads 0", clr_rd, 1'b0);
        tick(3);
        chk("R5 flag stays 0 after clear released", stat, 1'b0);
    endtask

    task automatic t_level_through_clear;
        tamper = 1'b1;
        tick(4);
        chk("R2 flag set by held input", stat, 1'b1);
        write_clear(1'b1);
        tick(4);
        chk("R5 held level cleared", stat, 1'b0);
        write_clear(1'b0);
        tick(5);
        chk("R5 held level does not reset flag", stat, 1'b0);
        chk("R6 no irq without flag", irq, 1'b0);
        tamper = 1'b0;
        tick(3);
        tamper = 1'b1;
        tick(2);
        chk("R5 new rise latency", stat, 1'b0);
        tick(1);
        chk("R5 new rise sets flag", stat, 1'b1);
        tamper = 1'b0;
        write_clear(1'b1);
        write_clear(1'b0);
        tick(1);
        chk("R5 cleared before power test", stat, 1'b0);
    endtask

    task automatic t_power_off;
        pwr_ok = 1'b0;
        tick(1);
        tamper = 1'b1;
        tick(3);
        tamper = 1'b0;
        chk("R7 flag set while unpowered", stat, 1'b1);
        chk("R7 no irq while unpowered", irq, 1'b0);
        write_clear(1'b1);
        chk("R8 unpowered write ignored", clr_rd, 1'b0);
        tick(1);
        chk("R8 flag kept after ignored write", stat, 1'b1);
        pwr_ok = 1'b1;
        #1;
        chk("R7 irq on power return", irq, 1'b1);
    endtask

    task automatic t_mask;
        mask = 1'b1;
        #1;
        chk("R6 mask blocks irq", irq, 1'b0);
        chk("R3 status unmasked", stat, 1'b1);
        tick(2);
        mask = 1'b0;
        #1;
        chk("R6 unmask restores irq", irq, 1'b1);
        tick(1);
    endtask

    task automatic t_battery_loss;
        write_clear(1'b1);
        write_clear(1'b0);
        tamper = 1'b1;
        tick(3);
        tamper = 1'b0;
        write_clear(1'b1);
        chk("R1 setup clear bit", clr_rd, 1'b1);
        bat_rst = 1'b1;
        tick(1);
        bat_rst = 1'b0;
        chk("R1 clear bit reset by battery loss", clr_rd, 1'b0);
        chk("R1 flag reset by battery loss", stat, 1'b0);
        tamper = 1'b1;
        tick(3);
        chk("R2 capture after battery reset", stat, 1'b1);
        tamper = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pulse_capture();
        t_clear_cycle();
        t_level_through_clear();
        t_power_off();
        t_mask();
        t_battery_loss();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule